// File: doc/BRIEF.md
# Periodic Multichannel Sample Packer

The block runs a repeating acquisition loop. At the start of each acquisition it asks the converter front end for one conversion of all channels. When the converter raises its valid strobe, the block captures the whole parallel sample bus. It then offers the captured samples to an outbound FIFO write port, one per clock cycle, beginning with channel 0 and counting upward.

Successive acquisitions are spaced by a period that the host programs in whole microseconds. The microsecond base comes from a prescaler on the system clock. The period never becomes shorter than one complete conversion-and-write sequence. A period of 0 or 1 means back-to-back acquisition.

The write port never stalls. If the FIFO is not ready in the cycle a sample is offered, that sample is lost and a sticky overflow flag is raised. The flag stays high until the host issues a synchronous clear. The clear also returns the loop to idle and resets the period timer. A run enable decides whether a new acquisition may begin.

Top module: `acq_frame_packer`

## Requirements
- R1: After the cycle in which `adc_valid` is captured, the block offers the NUM_CH samples in NUM_CH consecutive cycles, channel 0 first and in ascending order. The first offer falls in the cycle right after capture, which is two cycles after the `adc_start` pulse when the converter answers one cycle later. Channel c is taken from `adc_data[c*SAMPLE_W +: SAMPLE_W]`.
- R2: Each acquisition begins with a one-cycle `adc_start` pulse. The sample bus is captured in the cycle, after that pulse, in which `adc_valid` is high.
- R3: For a period P ≥ 2, the distance between consecutive `adc_start` pulses is P·(CLK_HZ/1,000,000) cycles, provided that this is at least the length of one acquisition.
- R4: For a period of 0 or 1, the next `adc_start` comes two cycles after the cycle in which the last channel was offered.
- R5: `fifo_valid` stays high for all NUM_CH offers of a frame whatever `fifo_ready` does. A refused sample is not retried, so every frame makes exactly NUM_CH offers.
- R6: In the cycle after one with `fifo_valid` high and `fifo_ready` low, `overflow` is high. It then stays high until a clear.
- R7: A cycle with `clr` high drives `overflow` low, stops any acquisition and resets the period timer. In the next cycle, `fifo_valid` and `adc_start` are both low.
- R8: While `run_en` is low, no new acquisition starts. A frame already in progress completes.
- R9: During reset, `fifo_valid`, `adc_start` and `overflow` are all low.
- R10: Samples are 26-bit signed fixed-point values (5 integer bits, 21 fractional bits). They pass to `fifo_data` bit for bit, with the sign preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear: overflow flag, timer, sequence |
| run_en | input | 1 | Allows new acquisitions to start |
| period_us | input | PERIOD_W | Acquisition period in microseconds |
| adc_start | output | 1 | Conversion request pulse |
| adc_valid | input | 1 | Conversion result strobe |
| adc_data | input | NUM_CH*SAMPLE_W | All channel samples, channel c at slice c |
| fifo_valid | output | 1 | Sample offered to FIFO |
| fifo_ready | input | 1 | FIFO can accept this cycle |
| fifo_data | output | SAMPLE_W | Offered sample |
| overflow | output | 1 | Sticky flag: a sample was lost |

## Verification
A corrupted channel counter or capture register would show up at `fifo_data` within the same frame, as samples out of order or with wrong values. It is visible no more than NUM_CH cycles after capture. A fault in the prescaler or microsecond counter would move the next `adc_start` by at least one cycle, so the bench measures the spacing between pulses exactly rather than within a tolerance. A latch that fails to set, or that leaks back low, shows on `overflow` in the cycle after a refused offer, or at any later idle sample.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_REQ,
    SEQ_CONV,
    SEQ_PUSH,
    SEQ_WAIT
  } seq_state_e;
endpackage

// File: rtl/acq_us_timer.sv
module acq_us_timer #(
  parameter int CLK_HZ   = 4_000_000,
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                start,
  input  logic [PERIOD_W-1:0] period_us,
  output logic                elapsed
);
  localparam int DIV   = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PERIOD_W-1:0] US_MAX = '1;

  logic [PRE_W-1:0]    pre_q, pre_d;
  logic [PERIOD_W-1:0] us_q, us_d;
  logic                tick, us_en, sat, near, asap;

  generate
    if (DIV == 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      assign tick = (pre_q == PRE_W'(DIV - 1));
    end
  endgenerate

  assign sat   = (us_q == US_MAX);
  assign us_en = clr | start | (tick & ~sat);

  // next-state: the start cycle itself counts as the first elapsed cycle
  always_comb begin
    pre_d = pre_q;
    us_d  = us_q;
    if (clr) begin
      pre_d = '0;
      us_d  = '0;
    end else if (start) begin
      if (DIV == 1) begin
        pre_d = '0;
        us_d  = PERIOD_W'(1);
      end else begin
        pre_d = PRE_W'(1);
        us_d  = '0;
      end
    end else begin
      pre_d = tick ? '0 : pre_q + PRE_W'(1);
      us_d  = us_q + PERIOD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      us_q <= '0;
    end else if (us_en) begin
      us_q <= us_d;
    end
  end

  // look one cycle ahead so start-to-start equals period * DIV exactly
  assign asap    = (period_us <= PERIOD_W'(1));
  assign near    = tick & (({1'b0, us_q} + (PERIOD_W+1)'(1)) == {1'b0, period_us});
  assign elapsed = asap | (us_q >= period_us) | near;

  assert_us_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !start && !clr && !sat) |=> (us_q == $past(us_q) + PERIOD_W'(1)));

  assert_us_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (us_q == '0));
endmodule

// File: rtl/acq_chan_seq.sv
module acq_chan_seq
  import acq_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 26
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       run_en,
  input  logic                       elapsed,
  input  logic                       adc_valid,
  input  logic [NUM_CH*SAMPLE_W-1:0] adc_data,
  output logic                       adc_start,
  output logic                       tmr_start,
  output logic                       push_valid,
  output logic [SAMPLE_W-1:0]        push_data
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [CH_W-1:0] CH_LAST = CH_W'(NUM_CH - 1);

  seq_state_e       state_q, state_d;
  logic [CH_W-1:0]  ch_q, ch_d;
  logic             ch_en, cap_en;
  logic [SAMPLE_W-1:0] cap_q [NUM_CH];

  assign cap_en = (state_q == SEQ_CONV) & adc_valid;
  assign ch_en  = cap_en | (state_q == SEQ_PUSH);

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    unique case (state_q)
      SEQ_IDLE: if (run_en) state_d = SEQ_REQ;
      SEQ_REQ:  state_d = SEQ_CONV;
      SEQ_CONV: if (adc_valid) begin
        state_d = SEQ_PUSH;
        ch_d    = '0;
      end
      SEQ_PUSH: begin
        ch_d = ch_q + CH_W'(1);
        if (ch_q == CH_LAST) state_d = SEQ_WAIT;
      end
      SEQ_WAIT: if (elapsed) state_d = run_en ? SEQ_REQ : SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
    if (clr) state_d = SEQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q <= '0;
    end else if (ch_en) begin
      ch_q <= ch_d;
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_cap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cap_q[g] <= '0;
        end else if (cap_en) begin
          cap_q[g] <= adc_data[g*SAMPLE_W +: SAMPLE_W];
        end
      end
    end
  endgenerate

  assign adc_start  = (state_q == SEQ_REQ);
  assign tmr_start  = (state_q == SEQ_REQ);
  assign push_valid = (state_q == SEQ_PUSH);
  assign push_data  = cap_q[ch_q];

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  assert_burst_unbroken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && (ch_q != CH_LAST) && !clr) |=> push_valid);

  assert_no_start_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == SEQ_IDLE) && !run_en) |=> !adc_start);
endmodule

// File: rtl/acq_ovf_latch.sv
module acq_ovf_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic offer,
  input  logic accept,
  output logic flag
);
  logic drop, flag_d, flag_en;

  assign drop    = offer & ~accept;
  assign flag_en = clr | drop;
  assign flag_d  = ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (flag_en) begin
      flag <= flag_d;
    end
  end

  assert_drop_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (offer && !accept && !clr) |=> flag);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  assert_clr_drops_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag);
endmodule

// File: rtl/acq_frame_packer.sv
module acq_frame_packer #(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 26,
  parameter int CLK_HZ   = 4_000_000,
  parameter int PERIOD_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       run_en,
  input  logic [PERIOD_W-1:0]        period_us,
  output logic                       adc_start,
  input  logic                       adc_valid,
  input  logic [NUM_CH*SAMPLE_W-1:0] adc_data,
  output logic                       fifo_valid,
  input  logic                       fifo_ready,
  output logic [SAMPLE_W-1:0]        fifo_data,
  output logic                       overflow
);
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  logic       elapsed, tmr_start;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_s = rst_pipe[1];

  acq_us_timer #(
    .CLK_HZ   (CLK_HZ),
    .PERIOD_W (PERIOD_W)
  ) i_timer (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr       (clr),
    .start     (tmr_start),
    .period_us (period_us),
    .elapsed   (elapsed)
  );

  acq_chan_seq #(
    .NUM_CH   (NUM_CH),
    .SAMPLE_W (SAMPLE_W)
  ) i_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .clr        (clr),
    .run_en     (run_en),
    .elapsed    (elapsed),
    .adc_valid  (adc_valid),
    .adc_data   (adc_data),
    .adc_start  (adc_start),
    .tmr_start  (tmr_start),
    .push_valid (fifo_valid),
    .push_data  (fifo_data)
  );

  acq_ovf_latch i_ovf (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr    (clr),
    .offer  (fifo_valid),
    .accept (fifo_ready),
    .flag   (overflow)
  );

  assert_clr_aborts_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    clr |=> (!fifo_valid && !adc_start));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n_s |-> (!fifo_valid && !adc_start && !overflow));
endmodule

// File: tb/test_acq_frame_packer.sv
module test_acq_frame_packer;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 4;
  localparam int SW   = 26;
  localparam int DIVT = 4;
  localparam int PW   = 16;
  localparam int NV   = 5;

  typedef struct packed {
    logic [PW-1:0]  per;
    logic [NCH-1:0] mask;
    logic [15:0]    ivl;
    logic           ovf;
  } vec_t;

  // period, ready mask per channel, expected start spacing, expected overflow
  localparam vec_t VEC [NV] = '{
    '{16'd5, 4'b1111, 16'd20, 1'b0},
    '{16'd0, 4'b1111, 16'd7,  1'b0},
    '{16'd1, 4'b1111, 16'd7,  1'b0},
    '{16'd2, 4'b1111, 16'd8,  1'b0},
    '{16'd3, 4'b1011, 16'd12, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n, clr, run_en, adc_valid, fifo_ready;
  logic [PW-1:0] period;
  logic [NCH*SW-1:0] adc_data;
  logic adc_start, fifo_valid, overflow;
  logic [SW-1:0] fifo_data;
  logic [NCH-1:0] rdy_mask;

  int cyc = 0, fcnt = 0, vpos = 0;
  int nstart = 0, nvld = 0, nacc = 0;
  int st_cyc [1024];
  int st_fr  [1024];
  int v_cyc  [1024];
  logic [SW-1:0] v_dat [1024];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acq_frame_packer #(
    .NUM_CH(NCH), .SAMPLE_W(SW), .CLK_HZ(DIVT*1_000_000), .PERIOD_W(PW)
  ) i_acq_frame_packer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run_en(run_en), .period_us(period),
    .adc_start(adc_start), .adc_valid(adc_valid), .adc_data(adc_data),
    .fifo_valid(fifo_valid), .fifo_ready(fifo_ready), .fifo_data(fifo_data),
    .overflow(overflow)
  );

  function automatic logic [SW-1:0] smp(int f, int c);
    logic [SW-1:0] v;
    v = SW'(f * 1000 + c * 7 + 3);
    if (c % 2 == 1) v = -v;
    return v;
  endfunction

  function automatic logic [NCH*SW-1:0] frame(int f);
    logic [NCH*SW-1:0] d;
    for (int c = 0; c < NCH; c++) d[c*SW +: SW] = smp(f, c);
    return d;
  endfunction

  // converter model: answers one cycle after the request
  always @(posedge clk) begin
    cyc <= cyc + 1;
    adc_valid <= adc_start;
    if (adc_start) begin
      adc_data <= frame(fcnt);
      fcnt <= fcnt + 1;
    end
    if (fifo_valid) vpos <= vpos + 1;
  end

  assign fifo_ready = rdy_mask[vpos % NCH];

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (adc_start) begin
        st_cyc[nstart % 1024] = cyc;
        st_fr[nstart % 1024]  = fcnt;
        nstart = nstart + 1;
      end
      if (fifo_valid) begin
        v_cyc[nvld % 1024] = cyc;
        v_dat[nvld % 1024] = fifo_data;
        nvld = nvld + 1;
        if (fifo_ready) nacc = nacc + 1;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
    end
  end

  initial begin
    int bs, bv, ba, pop, a0, a1;
    rst_n = 1'b0; clr = 1'b0; run_en = 1'b0; period = '0;
    adc_valid = 1'b0; adc_data = '0; rdy_mask = '1;
    repeat (3) @(posedge clk);
    #1;
    chk(fifo_valid == 1'b0, "R9", "fifo_valid in reset", fifo_valid, 0);
    chk(adc_start == 1'b0, "R9", "adc_start in reset", adc_start, 0);
    chk(overflow == 1'b0, "R9", "overflow in reset", overflow, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      bs = nstart; bv = nvld; ba = nacc;
      period = VEC[i].per; rdy_mask = VEC[i].mask; run_en = 1'b1;
      while (nstart < bs + 2) @(posedge clk);
      #1 run_en = 1'b0;
      repeat (40 + int'(VEC[i].per) * DIVT) @(posedge clk);
      #1;
      chk(st_cyc[bs+1] - st_cyc[bs] == int'(VEC[i].ivl),
          (VEC[i].per <= 1) ? "R4" : "R3", "start spacing",
          st_cyc[bs+1] - st_cyc[bs], VEC[i].ivl);
      if (VEC[i].per <= 1)
        chk(st_cyc[bs+1] == v_cyc[bv+NCH-1] + 2, "R4", "restart after last offer",
            st_cyc[bs+1], v_cyc[bv+NCH-1] + 2);
      for (int c = 0; c < NCH; c++) begin
        // R1 R2 R10: ordered, captured frame, signed value unchanged
        chk(v_dat[bv+c] == smp(st_fr[bs], c), "R1/R2/R10", "sample value",
            v_dat[bv+c], smp(st_fr[bs], c));
        chk(v_cyc[bv+c] == st_cyc[bs] + 2 + c, "R1", "offer cycle",
            v_cyc[bv+c], st_cyc[bs] + 2 + c);
      end
      chk(nvld - bv == 2*NCH, "R5", "offers in two frames", nvld - bv, 2*NCH);
      pop = $countones(VEC[i].mask);
      chk(nacc - ba == 2*pop, "R5", "accepted in two frames", nacc - ba, 2*pop);
      chk(overflow == VEC[i].ovf, "R6", "overflow after run", overflow, VEC[i].ovf);
      @(posedge clk); #1 clr = 1'b1;
      @(posedge clk); #1 clr = 1'b0;
      chk(overflow == 1'b0, "R7", "overflow after clr", overflow, 0);
    end

    // R8: no acquisition while disabled
    a0 = nstart; a1 = nvld;
    repeat (100) @(posedge clk);
    #1;
    chk(nstart == a0, "R8", "starts while disabled", nstart - a0, 0);
    chk(nvld == a1, "R8", "offers while disabled", nvld - a1, 0);

    // R6: overflow set the cycle after a refused offer
    rdy_mask = 4'b1110; period = 16'd10; run_en = 1'b1;
    while (!fifo_valid) begin @(posedge clk); #1; end
    chk(overflow == 1'b0, "R6", "overflow before drop", overflow, 0);
    @(posedge clk); #1;
    chk(overflow == 1'b1, "R6", "overflow after drop", overflow, 1);

    // R7: clear aborts a running frame
    clr = 1'b1; run_en = 1'b0;
    @(posedge clk); #1;
    chk(fifo_valid == 1'b0, "R7", "fifo_valid after clr", fifo_valid, 0);
    chk(adc_start == 1'b0, "R7", "adc_start after clr", adc_start, 0);
    chk(overflow == 1'b0, "R7", "overflow after clr", overflow, 0);
    clr = 1'b0;
    a0 = nstart; a1 = nvld;
    repeat (60) @(posedge clk);
    #1;
    chk(nvld == a1, "R7", "offers after abort", nvld - a1, 0);
    chk(nstart == a0, "R7", "starts after abort", nstart - a0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule